// File: doc/BRIEF.md
# PTP Time Counter with Fractional Increment

This block keeps a free-running time of day for precision time stamping. On every core clock cycle, while it is enabled, it adds a programmable increment to a running time. The increment is a fixed-point nanosecond value with 32 integer bits and 32 fraction bits. Whole nanoseconds and a sub-nanosecond fraction therefore build up together, and the clock can run at any fractional rate. The nominal increment is (10^9 * 2^32) / f_core in Hz. Software trims the frequency by rewriting the increment at any time.

A small register port gives access to the registers. It has an address, 64-bit write data, a write strobe, a read strobe and registered read data. The registers are a configuration register with a run bit, the fraction time, the whole-nanosecond time and the increment.

A capture strobe latches the current nanosecond count and offers it on a valid/ready output to a neighbouring block. The output obeys back-pressure. While `cap_valid` is high and `cap_ready` is low, `cap_ns` and `cap_valid` hold. Further strobes in that state are ignored. When a transfer (`cap_valid && cap_ready`) and a strobe fall in the same cycle, the new value replaces the one being accepted.

Top module: `tod_counter`

## Requirements
- R1: After reset the run bit is 0, the nanosecond and fraction times are 0, the increment reads `INCR_RESET`, and `cap_valid` is 0.
- R2: Time advances only on cycles where the run bit (bit 0 of the configuration register, offset 0xF00) was 1 before the clock edge. Otherwise both time fields hold.
- R3: Each advancing cycle adds the increment as a 32.32 fixed-point value to the time. The low 32 bits of the increment are added to the 32-bit fraction. The carry out of that sum is added to the nanosecond count in the same cycle, together with increment bits 63:32.
- R4: The nanosecond count (offset 0xF10) is 64 bits wide and wraps modulo 2^64.
- R5: A write to the nanosecond register (0xF10) or the fraction register (0xF08) loads the written value. No increment is applied to either field in that cycle, so a read in the next cycle returns exactly the written value.
- R6: A write to the increment register (0xF18) is first used on the clock edge after the write edge. The write edge itself still uses the old increment.
- R7: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. The fraction register reads bits 63:32 as zero, and the configuration register reads bits 63:1 as zero.
- R8: Offsets other than 0xF00, 0xF08, 0xF10 and 0xF18 read as zero. Writes to them change nothing.
- R9: A `cap_strobe` accepted at an edge copies the nanosecond count from before that edge into `cap_ns` and sets `cap_valid`. A strobe is accepted when `cap_valid` is 0 or `cap_ready` is 1. A transfer without a strobe clears `cap_valid`.
- R10: While `cap_valid` is 1 and `cap_ready` is 0, `cap_ns` and `cap_valid` hold, and a strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (12) | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 64 | Registered read data |
| cap_strobe | input | 1 | Request to capture the nanosecond count |
| cap_valid | output | 1 | Captured value is pending |
| cap_ready | input | 1 | Consumer accepts the captured value |
| cap_ns | output | 64 | Captured nanosecond count |

## Verification
The following are checked by assertions on every cycle:
- both time fields hold when the counter is stopped and nothing is written;
- a load of either time field takes the written value;
- the nanosecond count moves on every advancing cycle that has a non-zero integer increment;
- undefined offsets and the unused upper bits read as zero;
- the capture output holds under back-pressure and is cleared by a transfer.

The exact sums need the bench's directed scenarios, because they depend on cycle counts and on the increment. Those scenarios cover:
- a fraction carry into the nanosecond count;
- the wrap at 2^64;
- the dropped increment on a load;
- the one-cycle delay of a new increment;
- the timing of a strobe that coincides with a transfer.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 64;
  localparam int NS_W   = 64;
  localparam int FRAC_W = 32;
  localparam int INCR_W = 64;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 12'hF00;
  localparam logic [ADDR_W-1:0] OFF_FRAC = 12'hF08;
  localparam logic [ADDR_W-1:0] OFF_NS   = 12'hF10;
  localparam logic [ADDR_W-1:0] OFF_INCR = 12'hF18;

  typedef struct packed {
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
  } tod_t;
endpackage

// File: rtl/tod_csr.sv
module tod_csr
  import tod_pkg::*;
#(
  parameter logic [INCR_W-1:0] INCR_RESET = 64'h0000_0001_4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  tod_t              cur,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic [INCR_W-1:0] incr,
  output logic              ld_ns,
  output logic              ld_frac
);
  logic hit_cfg, hit_frac, hit_ns, hit_incr, hit_any;

  always_comb begin
    hit_cfg  = (addr == OFF_CFG);
    hit_frac = (addr == OFF_FRAC);
    hit_ns   = (addr == OFF_NS);
    hit_incr = (addr == OFF_INCR);
    hit_any  = hit_cfg | hit_frac | hit_ns | hit_incr;
    ld_ns    = wr & hit_ns;
    ld_frac  = wr & hit_frac;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      incr <= INCR_RESET;
    end else if (wr) begin
      if (hit_cfg)  run  <= wdata[0];
      if (hit_incr) incr <= wdata[INCR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        OFF_CFG:  rdata <= {{(DATA_W-1){1'b0}}, run};
        OFF_FRAC: rdata <= {{(DATA_W-FRAC_W){1'b0}}, cur.frac};
        OFF_NS:   rdata <= cur.ns;
        OFF_INCR: rdata <= incr;
        default:  rdata <= '0;
      endcase
    end
  end

  p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit_any) |=> (rdata == '0));
  p_frac_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_frac) |=> (rdata[DATA_W-1:FRAC_W] == '0));
  p_cfg_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_cfg) |=> (rdata[DATA_W-1:1] == '0));
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  p_undef_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit_any) |=> ($stable(run) && $stable(incr)));
endmodule

// File: rtl/tod_accum.sv
module tod_accum
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INCR_W-1:0] incr,
  input  logic              ld_ns,
  input  logic              ld_frac,
  input  logic [DATA_W-1:0] ld_val,
  output tod_t              cur
);
  logic [FRAC_W:0]   frac_sum;
  logic [NS_W-1:0]   ns_sum;

  always_comb begin
    frac_sum = {1'b0, cur.frac} + {1'b0, incr[FRAC_W-1:0]};
    ns_sum   = cur.ns + NS_W'(incr[INCR_W-1:FRAC_W]) + NS_W'(frac_sum[FRAC_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (ld_ns || ld_frac) begin
      if (ld_ns)   cur.ns   <= ld_val[NS_W-1:0];
      if (ld_frac) cur.frac <= ld_val[FRAC_W-1:0];
    end else if (run) begin
      cur.ns   <= ns_sum;
      cur.frac <= frac_sum[FRAC_W-1:0];
    end
  end

  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_ns && !ld_frac) |=> $stable(cur));
  p_load_ns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ns |=> (cur.ns == $past(ld_val[NS_W-1:0])));
  p_load_frac_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_frac |=> (cur.frac == $past(ld_val[FRAC_W-1:0])));
  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld_ns && !ld_frac && (incr[INCR_W-1:FRAC_W] != '0))
      |=> (cur.ns != $past(cur.ns)));
endmodule

// File: rtl/tod_capture.sv
module tod_capture
  import tod_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic            ready,
  input  logic [NS_W-1:0] ns,
  output logic            valid,
  output logic [NS_W-1:0] data
);
  logic take;

  always_comb take = strobe && (!valid || ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (take) begin
      valid <= 1'b1;
      data  <= ns;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  p_hold_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !valid) |=> (valid && (data == $past(ns))));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !strobe) |=> !valid);
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter logic [63:0] INCR_RESET = 64'h0000_0001_4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [63:0]       reg_rdata,
  input  logic              cap_strobe,
  output logic              cap_valid,
  input  logic              cap_ready,
  output logic [63:0]       cap_ns
);
  tod_t              cur;
  logic              run;
  logic [INCR_W-1:0] incr;
  logic              ld_ns, ld_frac;

  tod_csr #(.INCR_RESET(INCR_RESET)) u_csr (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .wr(reg_wr), .rd(reg_rd), .cur(cur), .rdata(reg_rdata),
    .run(run), .incr(incr), .ld_ns(ld_ns), .ld_frac(ld_frac)
  );

  tod_accum u_accum (
    .clk(clk), .rst_n(rst_n), .run(run), .incr(incr),
    .ld_ns(ld_ns), .ld_frac(ld_frac), .ld_val(reg_wdata), .cur(cur)
  );

  tod_capture u_cap (
    .clk(clk), .rst_n(rst_n), .strobe(cap_strobe), .ready(cap_ready),
    .ns(cur.ns), .valid(cap_valid), .data(cap_ns)
  );
endmodule

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
  localparam logic [63:0] INCR_DEF = 64'h0000_0001_4000_0000;
  localparam logic [11:0] A_CFG = 12'hF00, A_FRAC = 12'hF08,
                          A_NS = 12'hF10, A_INCR = 12'hF18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [63:0] reg_rdata;
  logic        cap_strobe = 1'b0, cap_valid, cap_ready = 1'b0;
  logic [63:0] cap_ns;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tod_counter #(.INCR_RESET(INCR_DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cap_strobe(cap_strobe), .cap_valid(cap_valid), .cap_ready(cap_ready),
    .cap_ns(cap_ns)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge (write edge between).
  task automatic wr(logic [11:0] a, logic [63:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(A_CFG, v);  chk("R1 cfg", v, 64'd0);
    rd(A_NS, v);   chk("R1 ns", v, 64'd0);
    rd(A_FRAC, v); chk("R1 frac", v, 64'd0);
    rd(A_INCR, v); chk("R1 incr", v, INCR_DEF);
    chk("R1 cap_valid", {63'd0, cap_valid}, 64'd0);
  endtask

  task automatic t_fields();
    logic [63:0] v;
    wr(A_FRAC, 64'hFFFF_FFFF_1234_5678);
    rd(A_FRAC, v); chk("R7 frac upper zero", v, 64'h0000_0000_1234_5678);
    wr(A_CFG, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(A_CFG, v);  chk("R7 cfg only bit0", v, 64'd0);
    @(negedge clk);
    chk("R7 rdata holds", reg_rdata, 64'd0);
  endtask

  task automatic t_run(string req, logic [63:0] x, logic [31:0] f,
                       logic [63:0] inc, int n);
    logic [63:0] v;
    logic [95:0] e;
    wr(A_CFG, 64'd0);
    wr(A_NS, x);
    wr(A_FRAC, {32'd0, f});
    wr(A_INCR, inc);
    wr(A_CFG, 64'd1);
    repeat (n - 1) @(negedge clk);
    wr(A_CFG, 64'd0);
    e = {x, f} + 96'(n) * {32'd0, inc};
    rd(A_NS, v);   chk({req, " ns"}, v, e[95:32]);
    rd(A_FRAC, v); chk({req, " frac"}, v, {32'd0, e[31:0]});
  endtask

  task automatic t_hold();
    logic [63:0] v;
    wr(A_CFG, 64'd0);
    wr(A_NS, 64'd42);
    repeat (10) @(negedge clk);
    rd(A_NS, v); chk("R2 stopped counter holds", v, 64'd42);
  endtask

  task automatic t_load_drop();
    logic [63:0] v;
    wr(A_CFG, 64'd0);
    wr(A_FRAC, 64'd0);
    wr(A_INCR, 64'h0000_0005_0000_0000);
    wr(A_CFG, 64'd1);
    wr(A_NS, 64'd1000);
    rd(A_NS, v); chk("R5 load exact while running", v, 64'd1000);
    rd(A_NS, v); chk("R3 advance after load", v, 64'd1005);
    wr(A_CFG, 64'd0);
    wr(A_FRAC, 64'h0000_0000_0000_0077);
    rd(A_FRAC, v); chk("R5 frac load", v, 64'h77);
  endtask

  task automatic t_incr_timing();
    logic [63:0] v;
    wr(A_CFG, 64'd0);
    wr(A_FRAC, 64'd0);
    wr(A_INCR, 64'h0000_000A_0000_0000);
    wr(A_CFG, 64'd1);
    wr(A_NS, 64'd0);
    wr(A_INCR, 64'h0000_0003_0000_0000);
    wr(A_CFG, 64'd0);
    rd(A_NS, v); chk("R6 new increment one cycle later", v, 64'd13);
  endtask

  task automatic t_undef();
    logic [63:0] v;
    wr(A_INCR, 64'h0000_0002_0000_0000);
    wr(12'hF20, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h000, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'hF20, v); chk("R8 undefined read", v, 64'd0);
    rd(12'hF04, v); chk("R8 misaligned read", v, 64'd0);
    rd(A_INCR, v);  chk("R8 incr untouched", v, 64'h0000_0002_0000_0000);
    rd(A_CFG, v);   chk("R8 cfg untouched", v, 64'd0);
  endtask

  task automatic t_capture();
    wr(A_CFG, 64'd0);
    wr(A_NS, 64'd777);
    cap_ready = 1'b0;
    cap_strobe = 1'b1; @(negedge clk); cap_strobe = 1'b0;
    chk("R9 valid after strobe", {63'd0, cap_valid}, 64'd1);
    chk("R9 captured ns", cap_ns, 64'd777);
    wr(A_NS, 64'd888);
    cap_strobe = 1'b1; @(negedge clk); cap_strobe = 1'b0;
    chk("R10 data held under back-pressure", cap_ns, 64'd777);
    chk("R10 valid held", {63'd0, cap_valid}, 64'd1);
    cap_ready = 1'b1; @(negedge clk); cap_ready = 1'b0;
    chk("R9 transfer clears valid", {63'd0, cap_valid}, 64'd0);
    cap_strobe = 1'b1; @(negedge clk); cap_strobe = 1'b0;
    chk("R9 recapture", cap_ns, 64'd888);
    wr(A_NS, 64'd999);
    cap_strobe = 1'b1; cap_ready = 1'b1;
    @(negedge clk);
    cap_strobe = 1'b0; cap_ready = 1'b0;
    chk("R9 strobe with transfer replaces", cap_ns, 64'd999);
    chk("R9 valid stays on replace", {63'd0, cap_valid}, 64'd1);
    cap_ready = 1'b1; @(negedge clk); cap_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_hold();
    t_run("R3 fraction carry", 64'd100, 32'hFFFF_FFFF, 64'h0000_0002_0000_0001, 1);
    t_run("R3 fractional rate", 64'd5000, 32'h1234_0000, 64'h0000_0014_5555_5555, 37);
    t_run("R4 wrap", 64'hFFFF_FFFF_FFFF_FFFD, 32'd0, 64'h0000_0001_0000_0000, 5);
    t_load_drop();
    t_incr_timing();
    t_undef();
    t_capture();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule